// File: doc/BRIEF.md
# Rotated immediate encoder

This unit decides how a 32-bit constant can be placed into a move-type instruction whose operand field holds an 8-bit value together with a 4-bit rotate code. The operand is rebuilt by rotating the 8-bit value right by twice the rotate code, so only even rotations from 0 to 30 bits are reachable. The encoder searches that space one rotation per clock cycle. If the constant itself cannot be built this way, it searches again using the bitwise inverse of the constant, which suits a move-inverted instruction. If both searches fail, it reports that the constant has to be fetched by a PC-relative load from a constant table.

A caller pulses `start_i` with the constant while the unit is idle and then waits for `done_o`. The result kind, the 8-bit value and the rotate code stay valid from that pulse until the next accepted request. A separate combinational expander module (`rimm_expand`) rebuilds the 32-bit word from a value and rotate code, so any encoding can be checked against its source.

Top module: `rimm_encoder`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `kind_o`, `imm_o` and `rot_o` are all zero.
- R2: A `start_i` seen on a rising edge while idle makes `busy_o` high after that edge and captures `const_i`.
- R3: Result kind 2'b00 (direct) is reported whenever the constant equals some 8-bit value rotated right by 2*rot. The reported `rot_o` is the smallest such code, and `imm_o` rotated right by 2*`rot_o` equals the constant.
- R4: For a direct result with rotate code r, `done_o` is high after the (r+2)-th rising edge, where the edge that samples `start_i` counts as the first.
- R5: Result kind 2'b01 (inverted) is reported when the constant is not direct but its bitwise inverse is. `imm_o` and `rot_o` then encode the inverse with the smallest rotate code r, and `done_o` comes after edge 18+r.
- R6: When neither form fits, result kind 2'b10 (constant table load) is reported with `imm_o` and `rot_o` zero, and `done_o` comes after edge 33.
- R7: `done_o` is high for exactly one cycle, `busy_o` is low whenever `done_o` is high, and the result outputs keep their values until the next accepted request completes.
- R8: `start_i` asserted while busy is ignored; the running search completes with the result and timing of the first constant.
- R9: The constant zero encodes as direct, value 0, rotate code 0.
- R10: The expander outputs its 8-bit input zero-extended to 32 bits and rotated right by twice its 4-bit rotate input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to encode `const_i` |
| const_i | input | 32 | Constant to encode |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| kind_o | output | 2 | 00 direct, 01 inverted, 10 constant table load |
| imm_o | output | 8 | 8-bit value of the encoding |
| rot_o | output | 4 | Rotate code; rotation is twice this value |

## Verification
A wrong rotate counter or phase register shows at the ports as a value/rotate pair that does not expand back to the constant or its inverse, or as a rotate code larger than the smallest one. It can also show as a `done_o` pulse one or more cycles away from the latency the rotate code predicts. Each of these is visible in the very cycle `done_o` rises. The sweeps cover every 8-bit value at every even rotation, many inverted constants, and many constants that fit neither form, so a fault in any single rotation step or in the phase change is exercised.

// File: rtl/rimm_pkg.sv
package rimm_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_IMM_W  = 8;
    localparam int unsigned DEF_ROT_W  = 4;

    // Result kinds reported on kind_o
    typedef enum logic [1:0] {
        KIND_DIRECT  = 2'b00,
        KIND_INVERT  = 2'b01,
        KIND_LITERAL = 2'b10
    } kind_e;

    // Search phases
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_DIRECT = 2'b01,
        ST_INVERT = 2'b10
    } phase_e;

endpackage

// File: rtl/rimm_expand.sv
// Combinational expander: value rotated right by twice the rotate code.
module rimm_expand #(
    parameter int unsigned WORD_W = rimm_pkg::DEF_WORD_W,
    parameter int unsigned IMM_W  = rimm_pkg::DEF_IMM_W,
    parameter int unsigned ROT_W  = rimm_pkg::DEF_ROT_W
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ROT_W-1:0]  rot_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int unsigned PAD_W = WORD_W - IMM_W;

    logic [WORD_W-1:0]   wide;
    logic [2*WORD_W-1:0] twice;
    logic [2*WORD_W-1:0] shifted;
    logic [ROT_W:0]      amount;

    always_comb begin
        wide    = {{PAD_W{1'b0}}, imm_i};
        amount  = {rot_i, 1'b0};
        twice   = {wide, wide};
        shifted = twice >> amount;
        word_o  = shifted[WORD_W-1:0];
    end
endmodule

// File: rtl/rimm_fit.sv
// Undoes one candidate rotation and tests whether the result fits the value field.
module rimm_fit #(
    parameter int unsigned WORD_W = rimm_pkg::DEF_WORD_W,
    parameter int unsigned IMM_W  = rimm_pkg::DEF_IMM_W,
    parameter int unsigned ROT_W  = rimm_pkg::DEF_ROT_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [ROT_W-1:0]  rot_i,
    output logic              fit_o,
    output logic [IMM_W-1:0]  imm_o
);
    logic [2*WORD_W-1:0] twice;
    logic [2*WORD_W-1:0] shifted;
    logic [WORD_W-1:0]   unrot;
    logic [ROT_W:0]      amount;

    always_comb begin
        amount  = {rot_i, 1'b0};
        twice   = {word_i, word_i};
        shifted = twice << amount;
        unrot   = shifted[2*WORD_W-1:WORD_W];
        fit_o   = (unrot[WORD_W-1:IMM_W] == '0);
        imm_o   = unrot[IMM_W-1:0];
    end
endmodule

// File: rtl/rimm_encoder.sv
module rimm_encoder #(
    parameter int unsigned WORD_W = rimm_pkg::DEF_WORD_W,
    parameter int unsigned IMM_W  = rimm_pkg::DEF_IMM_W,
    parameter int unsigned ROT_W  = rimm_pkg::DEF_ROT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] const_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        kind_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic [ROT_W-1:0]  rot_o
);
    import rimm_pkg::*;

    localparam int unsigned NUM_ROT  = 1 << ROT_W;
    localparam logic [ROT_W-1:0] LAST_ROT = ROT_W'(NUM_ROT - 1);

    typedef struct packed {
        phase_e             phase;
        logic [WORD_W-1:0]  base;
        logic [ROT_W-1:0]   step;
        logic               done;
        kind_e              kind;
        logic [IMM_W-1:0]   imm;
        logic [ROT_W-1:0]   rot;
    } enc_state_t;

    enc_state_t q, d;

    logic             fit_hit;
    logic [IMM_W-1:0] fit_imm;

    rimm_fit #(
        .WORD_W (WORD_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_fit (
        .word_i (q.base),
        .rot_i  (q.step),
        .fit_o  (fit_hit),
        .imm_o  (fit_imm)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            ST_IDLE: begin
                if (start_i) begin
                    d.phase = ST_DIRECT;
                    d.base  = const_i;
                    d.step  = '0;
                end
            end
            ST_DIRECT, ST_INVERT: begin
                if (fit_hit) begin
                    d.phase = ST_IDLE;
                    d.done  = 1'b1;
                    d.kind  = (q.phase == ST_DIRECT) ? KIND_DIRECT : KIND_INVERT;
                    d.imm   = fit_imm;
                    d.rot   = q.step;
                end else if (q.step == LAST_ROT) begin
                    if (q.phase == ST_DIRECT) begin
                        d.phase = ST_INVERT;
                        d.base  = ~q.base;
                        d.step  = '0;
                    end else begin
                        d.phase = ST_IDLE;
                        d.done  = 1'b1;
                        d.kind  = KIND_LITERAL;
                        d.imm   = '0;
                        d.rot   = '0;
                    end
                end else begin
                    d.step = q.step + ROT_W'(1);
                end
            end
            default: d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: ST_IDLE, base: '0, step: '0, done: 1'b0,
                   kind: KIND_DIRECT, imm: '0, rot: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.phase != ST_IDLE);
    assign done_o = q.done;
    assign kind_o = q.kind;
    assign imm_o  = q.imm;
    assign rot_o  = q.rot;

endmodule

// File: rtl/rimm_encoder_chk.sv
module rimm_encoder_chk #(
    parameter int unsigned WORD_W = rimm_pkg::DEF_WORD_W,
    parameter int unsigned IMM_W  = rimm_pkg::DEF_IMM_W,
    parameter int unsigned ROT_W  = rimm_pkg::DEF_ROT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        kind_o,
    input logic [IMM_W-1:0]  imm_o,
    input logic [ROT_W-1:0]  rot_o,
    input logic [WORD_W-1:0] base_q
);
    import rimm_pkg::*;

    logic [WORD_W-1:0] rebuilt;

    rimm_expand #(
        .WORD_W (WORD_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_exp (
        .imm_i  (imm_o),
        .rot_i  (rot_o),
        .word_o (rebuilt)
    );

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r3_direct_rebuilds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_o == KIND_DIRECT) |-> (rebuilt == base_q));

    a_r5_invert_rebuilds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_o == KIND_INVERT) |-> (rebuilt == base_q));

    a_r6_literal_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_o == KIND_LITERAL) |-> (imm_o == '0 && rot_o == '0));

    a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (kind_o != 2'b11));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(kind_o) && $stable(imm_o) && $stable(rot_o)));

endmodule

bind rimm_encoder rimm_encoder_chk #(
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .kind_o  (kind_o),
    .imm_o   (imm_o),
    .rot_o   (rot_o),
    .base_q  (q.base)
);

// File: tb/tb_rimm_encoder.sv
`timescale 1ns/1ps
module tb_rimm_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] const_i = '0;
    logic        busy_o, done_o;
    logic [1:0]  kind_o;
    logic [7:0]  imm_o;
    logic [3:0]  rot_o;
    logic [31:0] back_w;
    logic [7:0]  x_imm = '0;
    logic [3:0]  x_rot = '0;
    logic [31:0] x_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rimm_encoder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .const_i(const_i),
        .busy_o(busy_o), .done_o(done_o), .kind_o(kind_o),
        .imm_o(imm_o), .rot_o(rot_o)
    );

    rimm_expand u_back (.imm_i(imm_o), .rot_i(rot_o), .word_o(back_w));
    rimm_expand u_alone (.imm_i(x_imm), .rot_i(x_rot), .word_o(x_word));

    function automatic logic [31:0] rotl32(input logic [31:0] y, input int s);
        return (s == 0) ? y : ((y << s) | (y >> (32 - s)));
    endfunction

    function automatic logic [31:0] rotr32(input logic [31:0] y, input int s);
        return (s == 0) ? y : ((y >> s) | (y << (32 - s)));
    endfunction

    function automatic void model(input logic [31:0] x, output logic [1:0] k,
                                  output logic [7:0] v, output logic [3:0] r,
                                  output int lat);
        bit found = 0;
        k = 2'b10; v = '0; r = '0; lat = 33;
        for (int ph = 0; ph < 2; ph++) begin
            logic [31:0] y = (ph == 0) ? x : ~x;
            for (int rr = 0; rr < 16; rr++) begin
                logic [31:0] c = rotl32(y, 2 * rr);
                if (!found && c < 32'd256) begin
                    found = 1;
                    k = 2'(ph);
                    v = c[7:0];
                    r = 4'(rr);
                    lat = 2 + rr + 16 * ph;
                end
            end
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issues one request and waits for done; lat counts edges from the sampling edge.
    task automatic encode(input logic [31:0] c, output int lat);
        @(negedge clk);
        start_i = 1'b1;
        const_i = c;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 40) begin
            @(posedge clk);
            #1;
            lat++;
        end
    endtask

    task automatic run_one(input logic [31:0] c, input string req);
        logic [1:0] ek; logic [7:0] ev; logic [3:0] er; int el; int lat;
        model(c, ek, ev, er, el);
        encode(c, lat);
        check(kind_o == ek, req, $sformatf("kind for %h", c), 32'(kind_o), 32'(ek));
        check(imm_o == ev && rot_o == er, req, $sformatf("value/rot for %h", c),
              {20'd0, imm_o, rot_o}, {20'd0, ev, er});
        check(lat == el, (ek == 2'b00) ? "R4" : (ek == 2'b01) ? "R5" : "R6",
              $sformatf("latency for %h", c), 32'(lat), 32'(el));
        if (ek == 2'b00)
            check(back_w == c, "R3", "rebuild direct", back_w, c);
        else if (ek == 2'b01)
            check(back_w == ~c, "R5", "rebuild inverted", back_w, ~c);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [31:0] lfsr;
        logic [1:0]  hk; logic [7:0] hv; logic [3:0] hr;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(!busy_o && !done_o && kind_o == 0 && imm_o == 0 && rot_o == 0, "R1",
              "reset outputs", {busy_o, done_o, kind_o, imm_o, rot_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 start while idle raises busy
        @(negedge clk);
        start_i = 1'b1; const_i = 32'h0000_00FE;
        @(posedge clk); #1;
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 32'd1);
        while (!done_o) begin @(posedge clk); #1; end
        check(kind_o == 0 && imm_o == 8'hFE && rot_o == 0, "R3", "0xFE direct rot 0",
              {kind_o, imm_o, rot_o}, {2'b00, 8'hFE, 4'h0});
        // R7 one-cycle pulse, busy low, result held
        check(!busy_o, "R7", "busy low at done", 32'(busy_o), 32'd0);
        @(posedge clk); #1;
        check(!done_o, "R7", "done one cycle", 32'(done_o), 32'd0);
        repeat (4) @(posedge clk);
        #1;
        check(kind_o == 0 && imm_o == 8'hFE && rot_o == 0, "R7", "result held",
              {kind_o, imm_o, rot_o}, {2'b00, 8'hFE, 4'h0});

        // R9 zero
        run_one(32'h0, "R9");
        check(kind_o == 0 && imm_o == 0 && rot_o == 0, "R9", "zero encoding",
              {kind_o, imm_o, rot_o}, 32'd0);

        // Directed corners
        run_one(32'hFFFF_FFF0, "R5");
        check(kind_o == 2'b01 && imm_o == 8'h0F && rot_o == 0, "R5", "0xFFFFFFF0 inverted",
              {kind_o, imm_o, rot_o}, {2'b01, 8'h0F, 4'h0});
        run_one(32'hFF00_0000, "R3");
        check(rot_o == 4'd4 && imm_o == 8'hFF, "R3", "0xFF000000 rot 4",
              {imm_o, rot_o}, {8'hFF, 4'h4});
        run_one(32'hF000_000F, "R3");
        check(rot_o == 4'd2 && imm_o == 8'hFF, "R3", "wrapped 0xF000000F",
              {imm_o, rot_o}, {8'hFF, 4'h2});
        run_one(32'h0000_0101, "R6");
        check(kind_o == 2'b10, "R6", "0x101 needs table", 32'(kind_o), 32'd2);

        // R8 start while busy ignored
        @(negedge clk);
        start_i = 1'b1; const_i = 32'h1234_5678;
        @(posedge clk); #1;
        start_i = 1'b0;
        lat = 1;
        repeat (5) begin @(posedge clk); #1; lat++; end
        @(negedge clk);
        start_i = 1'b1; const_i = 32'h0000_00FE;
        @(posedge clk); #1;
        start_i = 1'b0; lat++;
        while (!done_o && lat < 40) begin @(posedge clk); #1; lat++; end
        check(kind_o == 2'b10 && imm_o == 0 && rot_o == 0, "R8", "ignored second start",
              {kind_o, imm_o, rot_o}, {2'b10, 12'h0});
        check(lat == 33, "R8", "latency of first request", 32'(lat), 32'd33);

        // R10 standalone expander
        for (int v = 0; v < 256; v += 17) begin
            for (int r = 0; r < 16; r++) begin
                x_imm = 8'(v); x_rot = 4'(r);
                #1;
                check(x_word == rotr32(32'(v), 2 * r), "R10", "expander",
                      x_word, rotr32(32'(v), 2 * r));
            end
        end

        // R3/R4 sweep: every value at every even rotation
        for (int v = 0; v < 256; v++) begin
            for (int r = 0; r < 16; r++) begin
                run_one(rotr32(32'(v), 2 * r), "R3");
            end
        end

        // R5 sweep: inverted forms
        for (int v = 0; v < 256; v += 7) begin
            for (int r = 0; r < 16; r++) begin
                run_one(~rotr32(32'(v), 2 * r), "R5");
            end
        end

        // R6 sweep: pseudo-random words, mostly needing the table
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            model(lfsr, hk, hv, hr, lat);
            run_one(lfsr, (hk == 2'b10) ? "R6" : "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule